// File: doc/BRIEF.md
# Dual-Pair Classification Overcurrent Supervisor

This block sequences a power-sourcing controller that feeds a link over two wire pairs. A global phase machine and two per-pair phase machines, primary and secondary, each step through four phases: idle, detect, classify and power-on. The phases advance on per-machine completion strobes. Classification current codes from the measurement path are compared against a limit parameter inside the block. A hit during classification latches a per-machine limit flag.

A limit hit on one pair sends only that pair's machine back to its own idle phase. The other pair and the global machine carry on. A global limit hit, an external fault, or a controller reset request sends the global machine to idle and takes both pair machines and their flags with it. Clearing the enable holds every machine in idle. The pair machines may only leave idle while the global machine is out of idle.

Top module: `pse_class_supervisor`

## Requirements
- R1: Under the synchronous reset `rst`, every state output reads 0 (idle) and every classification-active, power-enable and limit flag output reads 0.
- R2: With no forcing condition, a done strobe moves a machine along the encoding idle=0 → detect=1 → classify=2 → power-on=3 at the next edge. Power-on holds, and a done strobe there is ignored.
- R3: A classification-active output is 1 exactly when its machine's state is 2. A power-enable output is 1 exactly when its state is 3.
- R4: A current code at or above `LIM_CODE` (equality counts) while the machine is in state 2 sets that machine's limit flag at the next edge. A code of `LIM_CODE`-1 does not set it.
- R5: A current code at or above the limit while the machine is in any state other than 2 leaves its limit flag at 0.
- R6: In the cycle where a limit hit occurs in state 2, that machine's done strobe is ignored and the machine stays in state 2.
- R7: A set limit flag forces its machine to state 0 at the next edge. The flag stays set until the first edge at which the machine is already in state 0, and is then cleared. While the flag is set, a done strobe in state 0 is ignored.
- R8: A primary limit flag moves neither the global machine nor the secondary machine.
- R9: A secondary limit flag moves neither the global machine nor the primary machine.
- R10: With enable high, any of the controller reset request, the global limit flag or the fault input forces all three machines to state 0 at the next edge and clears both pair flags, overriding any done strobe.
- R11: With enable low, all machines go to or stay in state 0 at the next edge, whatever the done strobes.
- R12: While the global state is 0, both pair machines stay in state 0 even with their done strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Controller enable |
| pse_rst_i | input | 1 | Controller reset request (forces global idle when enabled) |
| fault_i | input | 1 | Error condition (forces global idle when enabled) |
| glb_done_i | input | 1 | Global phase-done strobe |
| pri_done_i | input | 1 | Primary phase-done strobe |
| sec_done_i | input | 1 | Secondary phase-done strobe |
| glb_cur_i | input | CUR_W | Total classification current code |
| pri_cur_i | input | CUR_W | Primary pair classification current code |
| sec_cur_i | input | CUR_W | Secondary pair classification current code |
| glb_state_o | output | 2 | Global phase encoding |
| pri_state_o | output | 2 | Primary phase encoding |
| sec_state_o | output | 2 | Secondary phase encoding |
| glb_cls_o | output | 1 | Global classification active |
| pri_cls_o | output | 1 | Primary classification active |
| sec_cls_o | output | 1 | Secondary classification active |
| glb_pwr_o | output | 1 | Global power enable |
| pri_pwr_o | output | 1 | Primary power enable |
| sec_pwr_o | output | 1 | Secondary power enable |
| glb_lim_o | output | 1 | Global classification limit flag |
| pri_lim_o | output | 1 | Primary classification limit flag |
| sec_lim_o | output | 1 | Secondary classification limit flag |

## Verification
The hardest case to reach is a pair-level limit hit while the other pair and the global machine sit in distinct non-idle phases. Only then does R8 or R9 show the hit staying local. The stimulus walks the global machine to classify, then steps each pair separately with its own done strobes until one pair sits in classify and the other in power-on. Only then is the limit code raised on one pair, at exactly the limit value. The same staging is reused with the global current, to show the global flag resetting both pairs one edge after it latches.

// File: rtl/pse_cls_pkg.sv
package pse_cls_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_DETECT   = 2'd1,
        PH_CLASSIFY = 2'd2,
        PH_POWER    = 2'd3
    } phase_e;

    localparam int NUM_MACH = 3;
    localparam int M_GLB    = 0;
    localparam int M_PRI    = 1;
    localparam int M_SEC    = 2;

    typedef struct packed {
        logic cls_act;
        logic pwr_en;
    } phase_out_t;

    typedef struct packed {
        logic enable;
        logic req_reset;
        logic fault;
        logic glb_flag;
        logic pri_flag;
        logic sec_flag;
    } hold_in_t;

    function automatic phase_e step_phase(input phase_e cur, input logic done,
                                          input logic block);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_IDLE:     if (done) nxt = PH_DETECT;
            PH_DETECT:   if (done) nxt = PH_CLASSIFY;
            PH_CLASSIFY: if (done && !block) nxt = PH_POWER;
            PH_POWER:    nxt = PH_POWER;
            default:     nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic phase_out_t decode_phase(input phase_e cur);
        phase_out_t o;
        o.cls_act = (cur == PH_CLASSIFY);
        o.pwr_en  = (cur == PH_POWER);
        return o;
    endfunction

endpackage

// File: rtl/pse_lim_latch.sv
module pse_lim_latch
    import pse_cls_pkg::*;
#(
    parameter int CUR_W    = 8,
    parameter int LIM_CODE = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             clr,
    input  logic [CUR_W-1:0] cur,
    output logic             hit,
    output logic             flag
);

    localparam logic [CUR_W-1:0] LIM_V = CUR_W'(LIM_CODE);

    logic flag_d;

    // Comparison is inclusive: a code equal to the limit counts as a hit.
    assign hit = (phase == PH_CLASSIFY) && (cur >= LIM_V);

    always_comb begin
        if (clr || (phase == PH_IDLE)) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= flag_d;
        end
    end

endmodule

// File: rtl/pse_phase_fsm.sv
module pse_phase_fsm
    import pse_cls_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   force_idle,
    input  logic   done,
    input  logic   block,
    output phase_e phase,
    output logic   cls_act,
    output logic   pwr_en
);

    phase_e     phase_d;
    phase_out_t dec;

    always_comb begin
        if (force_idle) begin
            phase_d = PH_IDLE;
        end else begin
            phase_d = step_phase(phase, done, block);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_d;
        end
    end

    assign dec     = decode_phase(phase);
    assign cls_act = dec.cls_act;
    assign pwr_en  = dec.pwr_en;

endmodule

// File: rtl/pse_hold_ctrl.sv
module pse_hold_ctrl
    import pse_cls_pkg::*;
(
    input  hold_in_t             hin,
    input  phase_e               glb_phase,
    output logic [NUM_MACH-1:0]  hold,
    output logic [NUM_MACH-1:0]  clr
);

    logic glb_force;
    logic sub_force;

    // Global forcing: disabled, or enabled with any of the three causes.
    assign glb_force = !hin.enable || hin.req_reset || hin.fault || hin.glb_flag;
    // Pair machines follow the global force in the same edge and are
    // pinned to idle while the global machine sits in idle.
    assign sub_force = glb_force || (glb_phase == PH_IDLE);

    always_comb begin
        hold        = '0;
        clr         = '0;
        hold[M_GLB] = glb_force;
        hold[M_PRI] = sub_force || hin.pri_flag;
        hold[M_SEC] = sub_force || hin.sec_flag;
        clr[M_PRI]  = sub_force;
        clr[M_SEC]  = sub_force;
    end

endmodule

// File: rtl/pse_class_supervisor.sv
module pse_class_supervisor
    import pse_cls_pkg::*;
#(
    parameter int CUR_W    = 8,
    parameter int LIM_CODE = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             pse_rst_i,
    input  logic             fault_i,
    input  logic             glb_done_i,
    input  logic             pri_done_i,
    input  logic             sec_done_i,
    input  logic [CUR_W-1:0] glb_cur_i,
    input  logic [CUR_W-1:0] pri_cur_i,
    input  logic [CUR_W-1:0] sec_cur_i,
    output logic [1:0]       glb_state_o,
    output logic [1:0]       pri_state_o,
    output logic [1:0]       sec_state_o,
    output logic             glb_cls_o,
    output logic             pri_cls_o,
    output logic             sec_cls_o,
    output logic             glb_pwr_o,
    output logic             pri_pwr_o,
    output logic             sec_pwr_o,
    output logic             glb_lim_o,
    output logic             pri_lim_o,
    output logic             sec_lim_o
);

    logic [CUR_W-1:0]    cur_a   [NUM_MACH];
    logic [NUM_MACH-1:0] done_a;
    logic [NUM_MACH-1:0] hold_a;
    logic [NUM_MACH-1:0] clr_a;
    logic [NUM_MACH-1:0] hit_a;
    logic [NUM_MACH-1:0] flag_a;
    logic [NUM_MACH-1:0] cls_a;
    logic [NUM_MACH-1:0] pwr_a;
    phase_e              phase_a [NUM_MACH];
    hold_in_t            hin;

    assign cur_a[M_GLB]  = glb_cur_i;
    assign cur_a[M_PRI]  = pri_cur_i;
    assign cur_a[M_SEC]  = sec_cur_i;
    assign done_a[M_GLB] = glb_done_i;
    assign done_a[M_PRI] = pri_done_i;
    assign done_a[M_SEC] = sec_done_i;

    assign hin.enable    = en_i;
    assign hin.req_reset = pse_rst_i;
    assign hin.fault     = fault_i;
    assign hin.glb_flag  = flag_a[M_GLB];
    assign hin.pri_flag  = flag_a[M_PRI];
    assign hin.sec_flag  = flag_a[M_SEC];

    pse_hold_ctrl u_hold (
        .hin       (hin),
        .glb_phase (phase_a[M_GLB]),
        .hold      (hold_a),
        .clr       (clr_a)
    );

    for (genvar m = 0; m < NUM_MACH; m++) begin : g_mach
        pse_lim_latch #(
            .CUR_W    (CUR_W),
            .LIM_CODE (LIM_CODE)
        ) u_lim (
            .clk   (clk),
            .rst   (rst),
            .phase (phase_a[m]),
            .clr   (clr_a[m]),
            .cur   (cur_a[m]),
            .hit   (hit_a[m]),
            .flag  (flag_a[m])
        );

        pse_phase_fsm u_fsm (
            .clk        (clk),
            .rst        (rst),
            .force_idle (hold_a[m]),
            .done       (done_a[m]),
            .block      (hit_a[m]),
            .phase      (phase_a[m]),
            .cls_act    (cls_a[m]),
            .pwr_en     (pwr_a[m])
        );
    end

    assign glb_state_o = phase_a[M_GLB];
    assign pri_state_o = phase_a[M_PRI];
    assign sec_state_o = phase_a[M_SEC];
    assign glb_cls_o   = cls_a[M_GLB];
    assign pri_cls_o   = cls_a[M_PRI];
    assign sec_cls_o   = cls_a[M_SEC];
    assign glb_pwr_o   = pwr_a[M_GLB];
    assign pri_pwr_o   = pwr_a[M_PRI];
    assign sec_pwr_o   = pwr_a[M_SEC];
    assign glb_lim_o   = flag_a[M_GLB];
    assign pri_lim_o   = flag_a[M_PRI];
    assign sec_lim_o   = flag_a[M_SEC];

endmodule

// File: rtl/pse_class_supervisor_chk.sv
module pse_class_supervisor_chk #(
    parameter int CUR_W    = 8,
    parameter int LIM_CODE = 100
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             pse_rst_i,
    input logic             fault_i,
    input logic             glb_done_i,
    input logic             pri_done_i,
    input logic             sec_done_i,
    input logic [CUR_W-1:0] glb_cur_i,
    input logic [CUR_W-1:0] pri_cur_i,
    input logic [CUR_W-1:0] sec_cur_i,
    input logic [1:0]       glb_state_o,
    input logic [1:0]       pri_state_o,
    input logic [1:0]       sec_state_o,
    input logic             glb_cls_o,
    input logic             pri_cls_o,
    input logic             sec_cls_o,
    input logic             glb_pwr_o,
    input logic             pri_pwr_o,
    input logic             sec_pwr_o,
    input logic             glb_lim_o,
    input logic             pri_lim_o,
    input logic             sec_lim_o
);

    localparam logic [CUR_W-1:0] LIM_V = CUR_W'(LIM_CODE);

    logic calm;
    assign calm = en_i && !pse_rst_i && !fault_i && !glb_lim_o;

    AST_PRI_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pri_state_o == 2'd2 && pri_cur_i >= LIM_V && calm && glb_state_o != 2'd0) |=> pri_lim_o); // R4

    AST_FLAG_ONLY_FROM_CLASSIFY: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_lim_o) |-> $past(sec_state_o) == 2'd2); // R5

    AST_HIT_BLOCKS_DONE: assert property (@(posedge clk) disable iff (rst)
        (glb_state_o == 2'd2 && glb_cur_i >= LIM_V && calm) |=> glb_state_o == 2'd2); // R6

    AST_PRI_FLAG_FORCES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pri_lim_o && pri_state_o != 2'd0) |=> pri_state_o == 2'd0); // R7

    AST_PRI_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (calm && pri_lim_o && glb_state_o != 2'd0 && !sec_lim_o && sec_state_o == 2'd3)
        |=> (glb_state_o != 2'd0 && sec_state_o == 2'd3)); // R8

    AST_SEC_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (calm && sec_lim_o && glb_state_o != 2'd0 && !pri_lim_o && pri_state_o == 2'd3)
        |=> (glb_state_o != 2'd0 && pri_state_o == 2'd3)); // R9

    AST_GLOBAL_FORCE: assert property (@(posedge clk) disable iff (rst)
        (en_i && (pse_rst_i || fault_i || glb_lim_o))
        |=> (glb_state_o == 2'd0 && pri_state_o == 2'd0 && sec_state_o == 2'd0
             && !pri_lim_o && !sec_lim_o)); // R10

    AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (glb_state_o == 2'd0 && pri_state_o == 2'd0 && sec_state_o == 2'd0)); // R11

    AST_PAIRS_WAIT_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (glb_state_o == 2'd0) |=> (pri_state_o == 2'd0 && sec_state_o == 2'd0)); // R12

    AST_ACT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(pri_cls_o && pri_pwr_o) && !(sec_cls_o && sec_pwr_o) && !(glb_cls_o && glb_pwr_o)); // R3

    AST_POWER_STICKS: assert property (@(posedge clk) disable iff (rst)
        (calm && glb_state_o == 2'd3) |=> glb_state_o == 2'd3); // R2

endmodule

bind pse_class_supervisor pse_class_supervisor_chk #(
    .CUR_W    (CUR_W),
    .LIM_CODE (LIM_CODE)
) u_chk (.*);

// File: tb/pse_class_supervisor_tb.sv
`timescale 1ns/1ps
module pse_class_supervisor_tb;

    localparam int CUR_W = 8;
    localparam int LIM   = 100;
    localparam bit H = 1'b1;
    localparam bit L = 1'b0;

    typedef struct packed {
        bit       en; bit cr; bit ft; bit gd; bit pd; bit sd;
        bit [7:0] gc; bit [7:0] pc; bit [7:0] sc;
        bit [1:0] egs; bit [1:0] eps; bit [1:0] ess;
        bit       egf; bit epf; bit esf;
        bit [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{H,L,L,H,H,H, 8'd0,  8'd0,  8'd0,   2'd1,2'd0,2'd0, L,L,L, 4'd12},
        '{H,L,L,H,H,L, 8'd0,  8'd0,  8'd0,   2'd2,2'd1,2'd0, L,L,L, 4'd2},
        '{H,L,L,H,H,H, 8'd0,  8'd0,  8'd0,   2'd3,2'd2,2'd1, L,L,L, 4'd2},
        '{H,L,L,H,H,H, 8'd0,  8'd99, 8'd0,   2'd3,2'd3,2'd2, L,L,L, 4'd4},
        '{H,L,L,L,L,H, 8'd0,  8'd0,  8'd100, 2'd3,2'd3,2'd2, L,L,H, 4'd6},
        '{H,L,L,L,L,L, 8'd0,  8'd0,  8'd0,   2'd3,2'd3,2'd0, L,L,H, 4'd7},
        '{H,L,L,L,L,L, 8'd0,  8'd0,  8'd0,   2'd3,2'd3,2'd0, L,L,L, 4'd9},
        '{H,L,L,L,L,H, 8'd255,8'd255,8'd0,   2'd3,2'd3,2'd1, L,L,L, 4'd5},
        '{H,L,L,L,L,H, 8'd0,  8'd0,  8'd0,   2'd3,2'd3,2'd2, L,L,L, 4'd2},
        '{H,L,L,L,L,H, 8'd0,  8'd0,  8'd0,   2'd3,2'd3,2'd3, L,L,L, 4'd2},
        '{H,L,H,H,L,L, 8'd0,  8'd0,  8'd0,   2'd0,2'd0,2'd0, L,L,L, 4'd10},
        '{H,L,L,H,L,L, 8'd200,8'd0,  8'd0,   2'd1,2'd0,2'd0, L,L,L, 4'd5},
        '{H,L,L,H,H,H, 8'd0,  8'd0,  8'd0,   2'd2,2'd1,2'd1, L,L,L, 4'd12},
        '{H,L,L,L,H,H, 8'd50, 8'd0,  8'd0,   2'd2,2'd2,2'd2, L,L,L, 4'd4},
        '{H,L,L,L,H,H, 8'd0,  8'd100,8'd0,   2'd2,2'd2,2'd3, L,H,L, 4'd4},
        '{H,L,L,L,L,L, 8'd0,  8'd0,  8'd0,   2'd2,2'd0,2'd3, L,H,L, 4'd8},
        '{H,L,L,L,H,L, 8'd0,  8'd0,  8'd0,   2'd2,2'd0,2'd3, L,L,L, 4'd7},
        '{H,L,L,L,H,L, 8'd0,  8'd0,  8'd0,   2'd2,2'd1,2'd3, L,L,L, 4'd8},
        '{H,L,L,H,L,L, 8'd100,8'd0,  8'd0,   2'd2,2'd1,2'd3, H,L,L, 4'd6},
        '{H,L,L,L,L,L, 8'd0,  8'd0,  8'd0,   2'd0,2'd0,2'd0, H,L,L, 4'd10},
        '{H,L,L,H,L,L, 8'd0,  8'd0,  8'd0,   2'd0,2'd0,2'd0, L,L,L, 4'd10},
        '{H,L,L,H,L,L, 8'd0,  8'd0,  8'd0,   2'd1,2'd0,2'd0, L,L,L, 4'd2},
        '{H,H,L,H,L,L, 8'd0,  8'd0,  8'd0,   2'd0,2'd0,2'd0, L,L,L, 4'd10},
        '{L,L,L,H,H,H, 8'd0,  8'd0,  8'd0,   2'd0,2'd0,2'd0, L,L,L, 4'd11},
        '{H,L,L,H,L,L, 8'd0,  8'd0,  8'd0,   2'd1,2'd0,2'd0, L,L,L, 4'd11},
        '{L,L,L,L,L,L, 8'd0,  8'd0,  8'd0,   2'd0,2'd0,2'd0, L,L,L, 4'd11}
    };

    logic clk = 1'b0;
    logic rst;
    logic en_i, pse_rst_i, fault_i, glb_done_i, pri_done_i, sec_done_i;
    logic [CUR_W-1:0] glb_cur_i, pri_cur_i, sec_cur_i;
    logic [1:0] glb_state_o, pri_state_o, sec_state_o;
    logic glb_cls_o, pri_cls_o, sec_cls_o;
    logic glb_pwr_o, pri_pwr_o, sec_pwr_o;
    logic glb_lim_o, pri_lim_o, sec_lim_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pse_class_supervisor #(.CUR_W(CUR_W), .LIM_CODE(LIM)) u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .pse_rst_i(pse_rst_i), .fault_i(fault_i),
        .glb_done_i(glb_done_i), .pri_done_i(pri_done_i), .sec_done_i(sec_done_i),
        .glb_cur_i(glb_cur_i), .pri_cur_i(pri_cur_i), .sec_cur_i(sec_cur_i),
        .glb_state_o(glb_state_o), .pri_state_o(pri_state_o), .sec_state_o(sec_state_o),
        .glb_cls_o(glb_cls_o), .pri_cls_o(pri_cls_o), .sec_cls_o(sec_cls_o),
        .glb_pwr_o(glb_pwr_o), .pri_pwr_o(pri_pwr_o), .sec_pwr_o(sec_pwr_o),
        .glb_lim_o(glb_lim_o), .pri_lim_o(pri_lim_o), .sec_lim_o(sec_lim_o)
    );

    function automatic string req_tag(input bit [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            4'd12: return "R12";
            default: return "R?";
        endcase
    endfunction

    // State/flag comparison for one row, packed as {g,p,s states, g,p,s flags}.
    task automatic check_core(input string tag, input int row, input bit [8:0] exp_v);
        bit [8:0] act_v;
        act_v = {glb_state_o, pri_state_o, sec_state_o, glb_lim_o, pri_lim_o, sec_lim_o};
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s row %0d: actual %b expected %b", tag, row, act_v, exp_v);
        end
    endtask

    // R3: activity outputs follow the state encoding (2 = classify, 3 = power-on).
    task automatic check_r3(input int row, input bit [1:0] g, input bit [1:0] p, input bit [1:0] s);
        bit [5:0] act_v, exp_v;
        act_v = {glb_cls_o, pri_cls_o, sec_cls_o, glb_pwr_o, pri_pwr_o, sec_pwr_o};
        exp_v = {g == 2'd2, p == 2'd2, s == 2'd2, g == 2'd3, p == 2'd3, s == 2'd3};
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL R3 row %0d: actual %b expected %b", row, act_v, exp_v);
        end
    endtask

    task automatic idle_inputs();
        en_i = 1'b1; pse_rst_i = 1'b0; fault_i = 1'b0;
        glb_done_i = 1'b0; pri_done_i = 1'b0; sec_done_i = 1'b0;
        glb_cur_i = '0; pri_cur_i = '0; sec_cur_i = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_core("R1", -1, 9'b0);
        check_r3(-1, 2'd0, 2'd0, 2'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            en_i = TBL[i].en; pse_rst_i = TBL[i].cr; fault_i = TBL[i].ft;
            glb_done_i = TBL[i].gd; pri_done_i = TBL[i].pd; sec_done_i = TBL[i].sd;
            glb_cur_i = TBL[i].gc; pri_cur_i = TBL[i].pc; sec_cur_i = TBL[i].sc;
            @(posedge clk);
            #1;
            check_core(req_tag(TBL[i].req), i,
                       {TBL[i].egs, TBL[i].eps, TBL[i].ess, TBL[i].egf, TBL[i].epf, TBL[i].esf});
            check_r3(i, TBL[i].egs, TBL[i].eps, TBL[i].ess);
            @(negedge clk);
        end

        // R4 boundary on the global machine: LIM-1 in classify leaves flag clear.
        idle_inputs();
        glb_done_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        glb_done_i = 1'b0;
        glb_cur_i = 8'(LIM - 1);
        @(posedge clk); #1;
        check_core("R4", 100, {2'd2, 2'd0, 2'd0, 3'b000});
        @(negedge clk);

        // R1: mid-run reset returns everything to idle.
        glb_cur_i = '0;
        pri_done_i = 1'b1;
        @(posedge clk); #1;
        check_core("R12", 101, {2'd2, 2'd1, 2'd0, 3'b000});
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check_core("R1", 102, 9'b0);
        check_r3(102, 2'd0, 2'd0, 2'd0);
        @(negedge clk);
        rst = 1'b0;
        idle_inputs();
        @(posedge clk); #1;
        check_core("R1", 103, 9'b0);

        finish_run();
    end

endmodule